// File: doc/BRIEF.md
# Coded-Address Crosspoint Memory Reader

This block is a cycle-level model of a programmable crosspoint memory. Wires are not picked by a binary decoder. Each row wire and each column wire carries its own sparse k-hot code, and a wire takes part in an operation only when the applied code is exactly equal to its own. A small code table per dimension maps each logical wire index to that wire's code. Configuration fills the table, and the block raises a flag as long as two wires of one dimension hold the same code.

A read runs as a fixed sequence of phases, one cycle each:

1. Precharge clears every row line and every column line.
2. Column drive raises only the column line whose code matches.
3. Row select pulls up every row line that crosses the driven column at a crosspoint which is on, and latches the row selection.
4. Sample presents the selected row's level with a single-cycle valid pulse.

If no row is selected, the output is undriven and reads 0. Programming is a separate one-cycle write that sets or clears the crosspoint where the matching row meets the matching column. A write is refused while a read is in flight.

Top module: `xpm_reader`

## Requirements
- R1: After reset, no read is in flight (`rd_busy`=0, `rd_valid`=0), `cfg_dup`=0, and every crosspoint is off, so any read returns 0.
- R2: A `rd_start` accepted while idle makes `rd_busy` high from the next cycle on. It gives exactly one `rd_valid` pulse, in the fourth cycle after the accepting edge, and `rd_busy` is low again one cycle later.
- R3: During the valid pulse, `rd_data` equals the stored state of the crosspoint at the row and column whose table codes equal `rd_row_code` and `rd_col_code`. `rd_data` is never 1 outside the valid pulse.
- R4: A valid k-hot row code that matches no loaded row leaves every row deselected, and the read returns 0 with `rd_bad`=0.
- R5: A valid k-hot column code that matches no loaded column drives no column, and the read returns 0. At most one column line is ever high.
- R6: A read code that does not have exactly K_HOT bits set in either dimension gives `rd_bad`=1 with the valid pulse and `rd_data`=0.
- R7: A write with `wr_en`=1 while idle sets (`wr_val`=1) or clears (`wr_val`=0) the crosspoint at the matching row and column in one cycle. A following read shows the new value.
- R8: A write is ignored while `rd_busy` is high, and also in the same cycle as an accepted `rd_start`.
- R9: A `rd_start` raised while a read is in flight is ignored. The read in flight returns its own data, and no second valid pulse follows.
- R10: A configuration write (`cfg_dim`=0 for rows, 1 for columns) stores `cfg_code` for wire `cfg_idx`. `cfg_dup` is 1 from the next cycle while two loaded wires of one dimension share a code, and returns to 0 once the codes are unique again.
- R11: Every read starts from precharged lines. After a read that returned 1, a read of a crosspoint that is off returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Code table write strobe |
| cfg_dim | input | 1 | Table select: 0 row, 1 column |
| cfg_idx | input | IDX_W | Logical wire index |
| cfg_code | input | CODE_W | Code stored for that wire |
| wr_en | input | 1 | Crosspoint program request |
| wr_val | input | 1 | 1 sets, 0 clears the crosspoint |
| wr_row_code | input | CODE_W | Row code for programming |
| wr_col_code | input | CODE_W | Column code for programming |
| rd_start | input | 1 | Read request |
| rd_row_code | input | CODE_W | Row code for the read |
| rd_col_code | input | CODE_W | Column code for the read |
| rd_busy | output | 1 | Read sequence in flight |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 1 | Read result |
| rd_bad | output | 1 | Applied read code is not k-hot |
| cfg_dup | output | 1 | Duplicate code present in a table |

## Verification
The hardest case to reach from the ports is a collision between a programming request or a second read request and a read already in flight. Random traffic that waits for each operation to finish never produces it. Directed sequences therefore raise `wr_en` or `rd_start` in the cycles just after a read is accepted, and in the same cycle as the accepted request. The outcome is then observed through a later read of the targeted crosspoint, and through the value and count of valid pulses. Codes that are legal k-hot but absent from the tables, and codes with the wrong weight, are also applied on purpose, because a random pick among loaded wires never produces them.

// File: rtl/xpm_pkg.sv
package xpm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_COL,
    PH_ROW,
    PH_SAMP
  } phase_t;
endpackage

// File: rtl/xpm_code_table.sv
module xpm_code_table #(
  parameter int N  = 8,
  parameter int W  = 5,
  parameter int K  = 2,
  parameter int IW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [W-1:0] ld_code,
  input  logic [W-1:0] q_code,
  output logic [N-1:0] match,
  output logic         dup
);
  logic [N-1:0][W-1:0] code_q;
  logic [N-1:0]        used_q;
  logic                q_ok;

  assign q_ok = ($countones(q_code) == K);

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic hit_ld;
    assign hit_ld = ld_en && (ld_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[i] <= '0;
        used_q[i] <= 1'b0;
      end else if (hit_ld) begin
        code_q[i] <= ld_code;
        used_q[i] <= 1'b1;
      end
    end
    assign match[i] = used_q[i] && q_ok && (code_q[i] == q_code);
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (used_q[i] && used_q[j] && (code_q[i] == code_q[j])) dup = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xpm_cell_array.sv
module xpm_cell_array #(
  parameter int NROW = 8,
  parameter int NCOL = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_fire,
  input  logic                       wr_val,
  input  logic [NROW-1:0]            row_match,
  input  logic [NCOL-1:0]            col_match,
  input  logic [NCOL-1:0]            col_line,
  output logic [NROW-1:0]            row_pull,
  output logic [NROW-1:0][NCOL-1:0]  cells
);
  logic [NROW-1:0][NCOL-1:0] cells_d;
  logic                      cells_en;

  assign cells_en = wr_fire;

  always_comb begin
    cells_d = cells;
    for (int r = 0; r < NROW; r++) begin
      for (int c = 0; c < NCOL; c++) begin
        if (row_match[r] && col_match[c]) cells_d[r][c] = wr_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cells <= '0;
    else if (cells_en) cells <= cells_d;
  end

  for (genvar r = 0; r < NROW; r++) begin : g_pull
    assign row_pull[r] = |(cells[r] & col_line);
  end
endmodule

// File: rtl/xpm_read_seq.sv
module xpm_read_seq
  import xpm_pkg::*;
#(
  parameter int NROW   = 8,
  parameter int NCOL   = 8,
  parameter int CODE_W = 5,
  parameter int K_HOT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] row_code_in,
  input  logic [CODE_W-1:0] col_code_in,
  input  logic [NCOL-1:0]   col_match,
  input  logic [NROW-1:0]   row_match,
  input  logic [NROW-1:0]   row_pull,
  output logic              idle,
  output logic              busy,
  output logic [CODE_W-1:0] cap_row_code,
  output logic [CODE_W-1:0] cap_col_code,
  output logic [NCOL-1:0]   col_line,
  output logic              valid,
  output logic              data,
  output logic              bad
);
  phase_t            st_q, st_d;
  logic [NROW-1:0]   row_line_q, row_line_d;
  logic [NROW-1:0]   row_sel_q, row_sel_d;
  logic [NCOL-1:0]   col_line_q, col_line_d;
  logic [CODE_W-1:0] cap_row_d, cap_col_d;
  logic              codes_ok;

  always_comb begin
    st_d       = st_q;
    row_line_d = row_line_q;
    row_sel_d  = row_sel_q;
    col_line_d = col_line_q;
    cap_row_d  = cap_row_code;
    cap_col_d  = cap_col_code;
    case (st_q)
      PH_IDLE: begin
        if (start) begin
          cap_row_d = row_code_in;
          cap_col_d = col_code_in;
          st_d      = PH_PRE;
        end
      end
      PH_PRE: begin
        row_line_d = '0;
        row_sel_d  = '0;
        col_line_d = '0;
        st_d       = PH_COL;
      end
      PH_COL: begin
        col_line_d = col_match;
        st_d       = PH_ROW;
      end
      PH_ROW: begin
        row_line_d = row_pull;
        row_sel_d  = row_match;
        st_d       = PH_SAMP;
      end
      PH_SAMP: st_d = PH_IDLE;
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= PH_IDLE;
      row_line_q   <= '0;
      row_sel_q    <= '0;
      col_line_q   <= '0;
      cap_row_code <= '0;
      cap_col_code <= '0;
    end else begin
      st_q         <= st_d;
      row_line_q   <= row_line_d;
      row_sel_q    <= row_sel_d;
      col_line_q   <= col_line_d;
      cap_row_code <= cap_row_d;
      cap_col_code <= cap_col_d;
    end
  end

  assign codes_ok = ($countones(cap_row_code) == K_HOT) &&
                    ($countones(cap_col_code) == K_HOT);
  assign idle     = (st_q == PH_IDLE);
  assign busy     = !idle;
  assign col_line = col_line_q;
  assign valid    = (st_q == PH_SAMP);
  assign bad      = valid && !codes_ok;
  assign data     = valid && codes_ok && |(row_line_q & row_sel_q);
endmodule

// File: rtl/xpm_reader.sv
module xpm_reader #(
  parameter int NROW   = 8,
  parameter int NCOL   = 8,
  parameter int CODE_W = 5,
  parameter int K_HOT  = 2,
  localparam int NMAX  = (NROW > NCOL) ? NROW : NCOL,
  localparam int IDX_W = (NMAX > 1) ? $clog2(NMAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_dim,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              wr_en,
  input  logic              wr_val,
  input  logic [CODE_W-1:0] wr_row_code,
  input  logic [CODE_W-1:0] wr_col_code,
  input  logic              rd_start,
  input  logic [CODE_W-1:0] rd_row_code,
  input  logic [CODE_W-1:0] rd_col_code,
  output logic              rd_busy,
  output logic              rd_valid,
  output logic              rd_data,
  output logic              rd_bad,
  output logic              cfg_dup
);
  logic                      rst_s1, rst_sn;
  logic                      seq_idle;
  logic [CODE_W-1:0]         cap_row, cap_col, q_row, q_col;
  logic [NROW-1:0]           row_match, row_pull;
  logic [NCOL-1:0]           col_match, col_line;
  logic                      dup_row, dup_col, wr_fire;
  logic [NROW-1:0][NCOL-1:0] xp_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  assign q_row   = seq_idle ? wr_row_code : cap_row;
  assign q_col   = seq_idle ? wr_col_code : cap_col;
  assign wr_fire = wr_en && seq_idle && !rd_start;

  xpm_code_table #(.N(NROW), .W(CODE_W), .K(K_HOT), .IW(IDX_W)) u_rtab (
    .clk(clk), .rst_n(rst_sn), .ld_en(cfg_we && !cfg_dim), .ld_idx(cfg_idx),
    .ld_code(cfg_code), .q_code(q_row), .match(row_match), .dup(dup_row)
  );

  xpm_code_table #(.N(NCOL), .W(CODE_W), .K(K_HOT), .IW(IDX_W)) u_ctab (
    .clk(clk), .rst_n(rst_sn), .ld_en(cfg_we && cfg_dim), .ld_idx(cfg_idx),
    .ld_code(cfg_code), .q_code(q_col), .match(col_match), .dup(dup_col)
  );

  xpm_cell_array #(.NROW(NROW), .NCOL(NCOL)) u_arr (
    .clk(clk), .rst_n(rst_sn), .wr_fire(wr_fire), .wr_val(wr_val),
    .row_match(row_match), .col_match(col_match), .col_line(col_line),
    .row_pull(row_pull), .cells(xp_state)
  );

  xpm_read_seq #(.NROW(NROW), .NCOL(NCOL), .CODE_W(CODE_W), .K_HOT(K_HOT)) u_seq (
    .clk(clk), .rst_n(rst_sn), .start(rd_start), .row_code_in(rd_row_code),
    .col_code_in(rd_col_code), .col_match(col_match), .row_match(row_match),
    .row_pull(row_pull), .idle(seq_idle), .busy(rd_busy),
    .cap_row_code(cap_row), .cap_col_code(cap_col), .col_line(col_line),
    .valid(rd_valid), .data(rd_data), .bad(rd_bad)
  );

  assign cfg_dup = dup_row | dup_col;
endmodule

// File: rtl/xpm_reader_chk.sv
module xpm_reader_chk #(
  parameter int NROW = 8,
  parameter int NCOL = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rd_start,
  input logic                      rd_busy,
  input logic                      rd_valid,
  input logic                      rd_data,
  input logic                      rd_bad,
  input logic [NCOL-1:0]           col_line,
  input logic [NROW-1:0][NCOL-1:0] cells
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !rd_busy) |=> rd_busy);
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_data_in_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data |-> rd_valid);
  p_one_column_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_line));
  p_bad_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |-> (rd_valid && !rd_data));
  p_cells_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |=> $stable(cells));
endmodule

bind xpm_reader xpm_reader_chk #(.NROW(NROW), .NCOL(NCOL)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_busy(rd_busy),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_bad(rd_bad),
  .col_line(col_line), .cells(xp_state)
);

// File: tb/xpm_reader_bench.sv
`timescale 1ns/1ps
module xpm_reader_bench;
  localparam int NR = 8, NC = 8, CW = 5, KH = 2, IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_dim, wr_en, wr_val, rd_start;
  logic [IW-1:0] cfg_idx;
  logic [CW-1:0] cfg_code, wr_row_code, wr_col_code, rd_row_code, rd_col_code;
  logic rd_busy, rd_valid, rd_data, rd_bad, cfg_dup;

  int errors = 0, checks = 0;
  bit done = 0;
  bit mdl [NR][NC];

  always #10 clk = ~clk;

  xpm_reader #(.NROW(NR), .NCOL(NC), .CODE_W(CW), .K_HOT(KH)) u_xpm_reader (.*);

  function automatic logic [CW-1:0] nth_code(input int n);
    int cnt = 0;
    for (int v = 0; v < (1 << CW); v++) begin
      if ($countones(v) == KH) begin
        if (cnt == n) return CW'(v);
        cnt++;
      end
    end
    return '0;
  endfunction

  function automatic logic [CW-1:0] rcode(input int i); return nth_code(i); endfunction
  function automatic logic [CW-1:0] ccode(input int j); return nth_code(j + 2); endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input bit dim, input int idx, input logic [CW-1:0] code);
    @(negedge clk);
    cfg_we = 1; cfg_dim = dim; cfg_idx = IW'(idx); cfg_code = code;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr(input logic [CW-1:0] rc, input logic [CW-1:0] cc, input bit v);
    @(negedge clk);
    wr_en = 1; wr_row_code = rc; wr_col_code = cc; wr_val = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [CW-1:0] rc, input logic [CW-1:0] cc,
                    output bit d, output bit b, output bit tim_ok);
    @(negedge clk);
    rd_start = 1; rd_row_code = rc; rd_col_code = cc;
    @(negedge clk);
    rd_start = 0;
    tim_ok = rd_busy && !rd_valid;
    @(negedge clk);
    tim_ok &= !rd_valid;
    @(negedge clk);
    tim_ok &= !rd_valid;
    @(negedge clk);
    tim_ok &= rd_valid;
    d = rd_data; b = rd_bad;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit d, b, t;
    int r, c;
    void'($urandom(32'd1234));
    rst_n = 0; cfg_we = 0; cfg_dim = 0; cfg_idx = '0; cfg_code = '0;
    wr_en = 0; wr_val = 0; wr_row_code = '0; wr_col_code = '0;
    rd_start = 0; rd_row_code = '0; rd_col_code = '0;
    for (int i = 0; i < NR; i++) for (int j = 0; j < NC; j++) mdl[i][j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!rd_busy && !rd_valid && !cfg_dup, "R1 reset outputs", {rd_busy, rd_valid, cfg_dup}, 0);

    for (int i = 0; i < NR; i++) load(0, i, rcode(i));
    for (int j = 0; j < NC; j++) load(1, j, ccode(j));
    @(negedge clk);
    chk(cfg_dup == 0, "R10 unique tables", cfg_dup, 0);

    rd(rcode(5), ccode(6), d, b, t);
    chk(d == 0, "R1 cleared crosspoint", d, 0);
    chk(t, "R2 valid timing", t, 1);
    @(negedge clk);
    chk(!rd_valid && !rd_busy, "R2 pulse ends", {rd_valid, rd_busy}, 0);

    // column 3 holds 0 1 0 0 1 0 0 0
    wr(rcode(1), ccode(3), 1); mdl[1][3] = 1;
    wr(rcode(4), ccode(3), 1); mdl[4][3] = 1;
    rd(rcode(1), ccode(3), d, b, t);
    chk(d == 1, "R3 set row reads one", d, 1);
    rd(rcode(0), ccode(3), d, b, t);
    chk(d == 0, "R3 off row reads zero", d, 0);

    // R11: after a 1, an off crosspoint in another column reads 0
    rd(rcode(4), ccode(3), d, b, t);
    chk(d == 1, "R11 first read one", d, 1);
    rd(rcode(4), ccode(5), d, b, t);
    chk(d == 0, "R11 precharge clears", d, 0);

    wr(rcode(4), ccode(3), 0); mdl[4][3] = 0;
    rd(rcode(4), ccode(3), d, b, t);
    chk(d == 0, "R7 clear takes effect", d, 0);

    // R4: unused valid row code; R5: unused valid column code
    rd(nth_code(8), ccode(3), d, b, t);
    chk(d == 0 && b == 0, "R4 no row selected", {d, b}, 0);
    rd(rcode(1), nth_code(0), d, b, t);
    chk(d == 0 && b == 0, "R5 no column driven", {d, b}, 0);

    // R6: wrong-weight codes
    rd(5'b00111, ccode(3), d, b, t);
    chk(d == 0 && b == 1, "R6 bad row code", {d, b}, 1);
    rd(rcode(1), 5'b00001, d, b, t);
    chk(d == 0 && b == 1, "R6 bad column code", {d, b}, 1);

    // R8: write while busy
    @(negedge clk);
    rd_start = 1; rd_row_code = rcode(1); rd_col_code = ccode(3);
    @(negedge clk);
    rd_start = 0;
    wr_en = 1; wr_val = 1; wr_row_code = rcode(6); wr_col_code = ccode(6);
    repeat (3) @(negedge clk);
    wr_en = 0;
    chk(rd_valid && rd_data, "R8 read in flight", rd_data, 1);
    rd(rcode(6), ccode(6), d, b, t);
    chk(d == 0, "R8 write during busy ignored", d, 0);
    // R8: write in same cycle as accepted start
    @(negedge clk);
    rd_start = 1; rd_row_code = rcode(0); rd_col_code = ccode(0);
    wr_en = 1; wr_val = 1; wr_row_code = rcode(7); wr_col_code = ccode(7);
    @(negedge clk);
    rd_start = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rd(rcode(7), ccode(7), d, b, t);
    chk(d == 0, "R8 write with start ignored", d, 0);

    // R9: second start during read
    @(negedge clk);
    rd_start = 1; rd_row_code = rcode(0); rd_col_code = ccode(3);
    @(negedge clk);
    rd_start = 1; rd_row_code = rcode(1); rd_col_code = ccode(3);
    @(negedge clk);
    rd_start = 0;
    repeat (2) @(negedge clk);
    chk(rd_valid && rd_data == 0, "R9 in-flight read data", rd_data, 0);
    @(negedge clk);
    chk(!rd_valid && !rd_busy, "R9 no second read", {rd_valid, rd_busy}, 0);

    // random traffic against the model
    for (int n = 0; n < 300; n++) begin
      r = $urandom_range(NR - 1);
      c = $urandom_range(NC - 1);
      if ($urandom_range(1) == 1) begin
        bit v = 1'($urandom_range(1));
        wr(rcode(r), ccode(c), v);
        mdl[r][c] = v;
      end else begin
        rd(rcode(r), ccode(c), d, b, t);
        chk(d == mdl[r][c] && !b && t, "R3 R7 random read", d, int'(mdl[r][c]));
      end
    end

    // R10 duplicate detection
    load(0, 7, rcode(0));
    chk(cfg_dup == 1, "R10 row duplicate", cfg_dup, 1);
    load(0, 7, rcode(7));
    chk(cfg_dup == 0, "R10 row restored", cfg_dup, 0);
    load(1, 2, ccode(5));
    chk(cfg_dup == 1, "R10 column duplicate", cfg_dup, 1);
    load(1, 2, ccode(2));
    chk(cfg_dup == 0, "R10 column restored", cfg_dup, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule